// File: doc/BRIEF.md
# Cursor Register Arming Controller

This block holds the four cursor registers that software programs (control, position, surface base and height override) and presents their active copies to the cursor overlay. Every register write lands in a pending copy. The pending set reaches the active outputs only at a vertical-blank pulse, and only when an update has been armed and not cancelled since. This keeps the overlay from showing a half-written cursor.

A write to the base register arms the update. A control write that turns a disabled cursor on also arms it. A write to any other cursor register disarms an armed update that has not yet been applied. Software therefore writes height override, control, position and then base. A move only needs position followed by base. A read port returns the pending values, or the armed flag from a status address.

Top module: `cur_arm_top`

## Requirements
- R1: After reset every active output is zero (control mode 0 means the cursor is off), every pending register reads zero, and the status word reads zero (not armed).
- R2: A register write changes only the pending copy. The active outputs change on no cycle without a vblank pulse.
- R3: A write to the base register (address 2) arms the update. At the next vblank pulse all four pending registers are copied to the active outputs, and the armed flag (status address 4, bit 0) clears. A vblank pulse always leaves the flag clear.
- R4: A control write (address 0) with a non-zero mode field, made while the active mode is 0, arms the update by itself.
- R5: A write to position (address 1) or height override (address 3), or a control write that does not arm under R4, clears the armed flag.
- R6: A vblank pulse while not armed leaves the active outputs unchanged.
- R7: When an arming write and a vblank pulse fall in the same cycle, the transfer happens at that vblank and includes the value written in that cycle.
- R8: Writing only position and then base, followed by vblank, moves the cursor and leaves control, base-independent fields and height override as they were.
- R9: Field layout. Control has mode in bits 1:0 (0 off, 1/2/3 sizes 64/128/256), 180-degree rotation in bit 4, gamma in bit 8 and colour conversion in bit 9. Position has X magnitude in bits 11:0, X negative in bit 15, Y magnitude in bits 27:16 and Y negative in bit 31. Height override has the height in bits 7:0 and its enable in bit 31. Base uses all 32 bits. Other bits read back as zero.
- R10: Writes to addresses 4 to 7 change no pending register and leave the armed flag as it was.
- R11: A cancelling write in the same cycle as a vblank pulse blocks the transfer at that vblank.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write address |
| wr_data | input | 32 | Write data |
| vblank | input | 1 | One-cycle vertical-blank pulse |
| rd_addr | input | 3 | Read address |
| rd_data | output | 32 | Pending register value, or armed flag at address 4 |
| cur_mode | output | 2 | Active mode (0 = cursor off) |
| cur_rot180 | output | 1 | Active 180-degree rotation |
| cur_gamma | output | 1 | Active gamma enable |
| cur_csc | output | 1 | Active colour conversion enable |
| cur_x_neg | output | 1 | Active X sign |
| cur_x_mag | output | POS_W | Active X magnitude |
| cur_y_neg | output | 1 | Active Y sign |
| cur_y_mag | output | POS_W | Active Y magnitude |
| cur_base | output | BASE_W | Active surface base |
| cur_hgt_en | output | 1 | Active height-override enable |
| cur_hgt | output | HGT_W | Active height override |

## Verification
On every cycle the assertions check the following. The active outputs hold whenever no vblank arrives. A base write leaves the update armed, and position or height writes leave it disarmed. Any vblank leaves it disarmed. Undefined-address writes keep the flag, and a cancel coinciding with vblank stops the transfer. Only the bench scenarios can show which values actually reach the outputs: the full copy of pending values, the same-cycle transfer including the fresh write, the arm-on-enable case that depends on the active mode, and the field layout on readback.

// File: rtl/cur_arm_pkg.sv
package cur_arm_pkg;

  localparam int DATA_W = 32;
  localparam int ADDR_W = 3;
  localparam int NUM_REGS = 4;

  localparam logic [ADDR_W-1:0] ADR_CTRL = 3'd0;
  localparam logic [ADDR_W-1:0] ADR_POS  = 3'd1;
  localparam logic [ADDR_W-1:0] ADR_BASE = 3'd2;
  localparam logic [ADDR_W-1:0] ADR_HGT  = 3'd3;
  localparam logic [ADDR_W-1:0] ADR_STAT = 3'd4;

  localparam int CTL_MODE_LSB = 0;
  localparam int CTL_ROT_BIT  = 4;
  localparam int CTL_GAM_BIT  = 8;
  localparam int CTL_CSC_BIT  = 9;
  localparam int POS_XS_BIT   = 15;
  localparam int POS_Y_LSB    = 16;
  localparam int POS_YS_BIT   = 31;
  localparam int HGT_EN_BIT   = 31;

  typedef enum logic [1:0] {
    MODE_OFF = 2'd0,
    MODE_64  = 2'd1,
    MODE_128 = 2'd2,
    MODE_256 = 2'd3
  } cur_mode_e;

  typedef struct packed {
    logic      csc;
    logic      gamma;
    logic      rot180;
    cur_mode_e mode;
  } cur_ctrl_t;

endpackage

// File: rtl/cur_wr_decode.sv
module cur_wr_decode
  import cur_arm_pkg::*;
#(
  parameter int POS_W  = 12,
  parameter int BASE_W = 32,
  parameter int HGT_W  = 8
) (
  input  logic                 wr_en,
  input  logic [ADDR_W-1:0]    wr_addr,
  input  logic [DATA_W-1:0]    wr_data,
  input  logic                 act_enabled,
  output logic                 ld_ctrl,
  output logic                 ld_pos,
  output logic                 ld_base,
  output logic                 ld_hgt,
  output cur_ctrl_t            f_ctrl,
  output logic [2*POS_W+1:0]   f_pos,
  output logic [BASE_W-1:0]    f_base,
  output logic [HGT_W:0]       f_hgt,
  output logic                 arm_req,
  output logic                 cancel_req
);

  logic [NUM_REGS-1:0] sel;

  // one select line per implemented register
  for (genvar gi = 0; gi < NUM_REGS; gi++) begin : g_sel
    assign sel[gi] = wr_en && (wr_addr == ADDR_W'(gi));
  end

  assign ld_ctrl = sel[ADR_CTRL[1:0]];
  assign ld_pos  = sel[ADR_POS[1:0]];
  assign ld_base = sel[ADR_BASE[1:0]];
  assign ld_hgt  = sel[ADR_HGT[1:0]];

  always_comb begin
    f_ctrl.mode   = cur_mode_e'(wr_data[CTL_MODE_LSB +: 2]);
    f_ctrl.rot180 = wr_data[CTL_ROT_BIT];
    f_ctrl.gamma  = wr_data[CTL_GAM_BIT];
    f_ctrl.csc    = wr_data[CTL_CSC_BIT];
    f_pos  = {wr_data[POS_XS_BIT], wr_data[POS_W-1:0],
              wr_data[POS_YS_BIT], wr_data[POS_Y_LSB +: POS_W]};
    f_base = wr_data[BASE_W-1:0];
    f_hgt  = {wr_data[HGT_EN_BIT], wr_data[HGT_W-1:0]};
  end

  logic enabling;
  assign enabling   = ld_ctrl && (f_ctrl.mode != MODE_OFF) && !act_enabled;
  assign arm_req    = ld_base || enabling;
  assign cancel_req = (ld_ctrl && !enabling) || ld_pos || ld_hgt;

endmodule

// File: rtl/cur_pend_regs.sv
module cur_pend_regs
  import cur_arm_pkg::*;
#(
  parameter int POS_W  = 12,
  parameter int BASE_W = 32,
  parameter int HGT_W  = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ld_ctrl,
  input  logic               ld_pos,
  input  logic               ld_base,
  input  logic               ld_hgt,
  input  cur_ctrl_t          f_ctrl,
  input  logic [2*POS_W+1:0] f_pos,
  input  logic [BASE_W-1:0]  f_base,
  input  logic [HGT_W:0]     f_hgt,
  output cur_ctrl_t          pend_ctrl,
  output logic [2*POS_W+1:0] pend_pos,
  output logic [BASE_W-1:0]  pend_base,
  output logic [HGT_W:0]     pend_hgt,
  output cur_ctrl_t          nxt_ctrl,
  output logic [2*POS_W+1:0] nxt_pos,
  output logic [BASE_W-1:0]  nxt_base,
  output logic [HGT_W:0]     nxt_hgt
);

  always_comb begin
    nxt_ctrl = ld_ctrl ? f_ctrl : pend_ctrl;
    nxt_pos  = ld_pos  ? f_pos  : pend_pos;
    nxt_base = ld_base ? f_base : pend_base;
    nxt_hgt  = ld_hgt  ? f_hgt  : pend_hgt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_ctrl <= '0;
      pend_pos  <= '0;
      pend_base <= '0;
      pend_hgt  <= '0;
    end else begin
      if (ld_ctrl) pend_ctrl <= nxt_ctrl;
      if (ld_pos)  pend_pos  <= nxt_pos;
      if (ld_base) pend_base <= nxt_base;
      if (ld_hgt)  pend_hgt  <= nxt_hgt;
    end
  end

endmodule

// File: rtl/cur_arm_ctrl.sv
module cur_arm_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic vblank,
  input  logic arm_req,
  input  logic cancel_req,
  output logic armed,
  output logic xfer
);

  logic armed_eff;
  logic armed_d;
  logic armed_en;

  always_comb begin
    armed_eff = arm_req || (armed && !cancel_req);
    xfer      = vblank && armed_eff;
    armed_d   = vblank ? 1'b0 : armed_eff;
    armed_en  = vblank || arm_req || cancel_req;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed <= 1'b0;
    end else if (armed_en) begin
      armed <= armed_d;
    end
  end

endmodule

// File: rtl/cur_act_regs.sv
module cur_act_regs
  import cur_arm_pkg::*;
#(
  parameter int POS_W  = 12,
  parameter int BASE_W = 32,
  parameter int HGT_W  = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               xfer,
  input  cur_ctrl_t          nxt_ctrl,
  input  logic [2*POS_W+1:0] nxt_pos,
  input  logic [BASE_W-1:0]  nxt_base,
  input  logic [HGT_W:0]     nxt_hgt,
  output cur_ctrl_t          act_ctrl,
  output logic [2*POS_W+1:0] act_pos,
  output logic [BASE_W-1:0]  act_base,
  output logic [HGT_W:0]     act_hgt
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_ctrl <= '0;
      act_pos  <= '0;
      act_base <= '0;
      act_hgt  <= '0;
    end else if (xfer) begin
      act_ctrl <= nxt_ctrl;
      act_pos  <= nxt_pos;
      act_base <= nxt_base;
      act_hgt  <= nxt_hgt;
    end
  end

endmodule

// File: rtl/cur_arm_top.sv
module cur_arm_top
  import cur_arm_pkg::*;
#(
  parameter int POS_W  = 12,
  parameter int BASE_W = 32,
  parameter int HGT_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [2:0]        wr_addr,
  input  logic [31:0]       wr_data,
  input  logic              vblank,
  input  logic [2:0]        rd_addr,
  output logic [31:0]       rd_data,
  output logic [1:0]        cur_mode,
  output logic              cur_rot180,
  output logic              cur_gamma,
  output logic              cur_csc,
  output logic              cur_x_neg,
  output logic [POS_W-1:0]  cur_x_mag,
  output logic              cur_y_neg,
  output logic [POS_W-1:0]  cur_y_mag,
  output logic [BASE_W-1:0] cur_base,
  output logic              cur_hgt_en,
  output logic [HGT_W-1:0]  cur_hgt
);

  localparam int POS_VW  = 2*POS_W + 2;
  localparam int YN_IDX  = POS_W;
  localparam int XM_LSB  = POS_W + 1;
  localparam int XN_IDX  = 2*POS_W + 1;

  logic                 ld_ctrl, ld_pos, ld_base, ld_hgt;
  cur_ctrl_t            f_ctrl, pend_ctrl, nxt_ctrl, act_ctrl;
  logic [POS_VW-1:0]    f_pos, pend_pos, nxt_pos, act_pos;
  logic [BASE_W-1:0]    f_base, pend_base, nxt_base, act_base;
  logic [HGT_W:0]       f_hgt, pend_hgt, nxt_hgt, act_hgt;
  logic                 arm_req, cancel_req, upd_armed, xfer, act_enabled;

  assign act_enabled = (act_ctrl.mode != MODE_OFF);

  cur_wr_decode #(.POS_W(POS_W), .BASE_W(BASE_W), .HGT_W(HGT_W)) u_dec (
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .act_enabled(act_enabled),
    .ld_ctrl(ld_ctrl), .ld_pos(ld_pos), .ld_base(ld_base), .ld_hgt(ld_hgt),
    .f_ctrl(f_ctrl), .f_pos(f_pos), .f_base(f_base), .f_hgt(f_hgt),
    .arm_req(arm_req), .cancel_req(cancel_req)
  );

  cur_pend_regs #(.POS_W(POS_W), .BASE_W(BASE_W), .HGT_W(HGT_W)) u_pend (
    .clk(clk), .rst_n(rst_n),
    .ld_ctrl(ld_ctrl), .ld_pos(ld_pos), .ld_base(ld_base), .ld_hgt(ld_hgt),
    .f_ctrl(f_ctrl), .f_pos(f_pos), .f_base(f_base), .f_hgt(f_hgt),
    .pend_ctrl(pend_ctrl), .pend_pos(pend_pos), .pend_base(pend_base),
    .pend_hgt(pend_hgt),
    .nxt_ctrl(nxt_ctrl), .nxt_pos(nxt_pos), .nxt_base(nxt_base),
    .nxt_hgt(nxt_hgt)
  );

  cur_arm_ctrl u_arm (
    .clk(clk), .rst_n(rst_n), .vblank(vblank),
    .arm_req(arm_req), .cancel_req(cancel_req),
    .armed(upd_armed), .xfer(xfer)
  );

  cur_act_regs #(.POS_W(POS_W), .BASE_W(BASE_W), .HGT_W(HGT_W)) u_act (
    .clk(clk), .rst_n(rst_n), .xfer(xfer),
    .nxt_ctrl(nxt_ctrl), .nxt_pos(nxt_pos), .nxt_base(nxt_base),
    .nxt_hgt(nxt_hgt),
    .act_ctrl(act_ctrl), .act_pos(act_pos), .act_base(act_base),
    .act_hgt(act_hgt)
  );

  // readback of pending copies and the armed flag
  always_comb begin
    rd_data = '0;
    case (rd_addr)
      ADR_CTRL: begin
        rd_data[CTL_MODE_LSB +: 2] = pend_ctrl.mode;
        rd_data[CTL_ROT_BIT]       = pend_ctrl.rot180;
        rd_data[CTL_GAM_BIT]       = pend_ctrl.gamma;
        rd_data[CTL_CSC_BIT]       = pend_ctrl.csc;
      end
      ADR_POS: begin
        rd_data[POS_W-1:0]          = pend_pos[XN_IDX-1:XM_LSB];
        rd_data[POS_XS_BIT]         = pend_pos[XN_IDX];
        rd_data[POS_Y_LSB +: POS_W] = pend_pos[POS_W-1:0];
        rd_data[POS_YS_BIT]         = pend_pos[YN_IDX];
      end
      ADR_BASE: rd_data[BASE_W-1:0] = pend_base;
      ADR_HGT: begin
        rd_data[HGT_W-1:0] = pend_hgt[HGT_W-1:0];
        rd_data[HGT_EN_BIT] = pend_hgt[HGT_W];
      end
      ADR_STAT: rd_data[0] = upd_armed;
      default:  rd_data = '0;
    endcase
  end

  assign cur_mode   = act_ctrl.mode;
  assign cur_rot180 = act_ctrl.rot180;
  assign cur_gamma  = act_ctrl.gamma;
  assign cur_csc    = act_ctrl.csc;
  assign cur_x_neg  = act_pos[XN_IDX];
  assign cur_x_mag  = act_pos[XN_IDX-1:XM_LSB];
  assign cur_y_neg  = act_pos[YN_IDX];
  assign cur_y_mag  = act_pos[POS_W-1:0];
  assign cur_base   = act_base;
  assign cur_hgt_en = act_hgt[HGT_W];
  assign cur_hgt    = act_hgt[HGT_W-1:0];

endmodule

// File: rtl/cur_arm_chk.sv
module cur_arm_chk
  import cur_arm_pkg::*;
#(
  parameter int ACT_W = 64
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic [2:0]       wr_addr,
  input logic             vblank,
  input logic             armed,
  input logic [ACT_W-1:0] act_all
);

  // R2
  act_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !vblank |=> $stable(act_all));

  // R3
  base_arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == ADR_BASE && !vblank) |=> armed);

  // R3
  vblank_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vblank |=> !armed);

  // R5
  other_cancel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (wr_addr == ADR_POS || wr_addr == ADR_HGT)) |=> !armed);

  // R6
  idle_vblank_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (vblank && !armed && !wr_en) |=> $stable(act_all));

  // R10
  undef_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr >= ADR_STAT && !vblank) |=> (armed == $past(armed)));

  // R11
  cancel_vblank_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (vblank && wr_en && (wr_addr == ADR_POS || wr_addr == ADR_HGT))
      |=> $stable(act_all));

endmodule

bind cur_arm_top cur_arm_chk #(.ACT_W(5 + 2*POS_W + 2 + BASE_W + HGT_W + 1)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
  .vblank(vblank), .armed(upd_armed),
  .act_all({cur_mode, cur_rot180, cur_gamma, cur_csc, cur_x_neg, cur_x_mag,
            cur_y_neg, cur_y_mag, cur_base, cur_hgt_en, cur_hgt})
);

// File: tb/cur_arm_top_tb.sv
`timescale 1ns/1ps
module cur_arm_top_tb;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en;
  logic [2:0]  wr_addr;
  logic [31:0] wr_data;
  logic        vblank;
  logic [2:0]  rd_addr;
  logic [31:0] rd_data;
  logic [1:0]  cur_mode;
  logic        cur_rot180, cur_gamma, cur_csc, cur_x_neg, cur_y_neg, cur_hgt_en;
  logic [11:0] cur_x_mag, cur_y_mag;
  logic [31:0] cur_base;
  logic [7:0]  cur_hgt;

  int checks = 0;
  int errors = 0;

  logic [31:0] m_pend [4];
  logic [31:0] m_act  [4];
  logic        m_armed;

  always #4 clk = ~clk;

  cur_arm_top u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .vblank(vblank), .rd_addr(rd_addr), .rd_data(rd_data),
    .cur_mode(cur_mode), .cur_rot180(cur_rot180), .cur_gamma(cur_gamma),
    .cur_csc(cur_csc), .cur_x_neg(cur_x_neg), .cur_x_mag(cur_x_mag),
    .cur_y_neg(cur_y_neg), .cur_y_mag(cur_y_mag), .cur_base(cur_base),
    .cur_hgt_en(cur_hgt_en), .cur_hgt(cur_hgt)
  );

  // R9 field masks per register index
  function automatic logic [31:0] mask_of(input int idx);
    case (idx)
      0: return 32'h0000_0313;
      1: return 32'h8FFF_8FFF;
      2: return 32'hFFFF_FFFF;
      default: return 32'h8000_00FF;
    endcase
  endfunction

  function automatic logic [31:0] act_word(input int idx);
    logic [31:0] w;
    w = '0;
    case (idx)
      0: begin w[1:0] = cur_mode; w[4] = cur_rot180; w[8] = cur_gamma; w[9] = cur_csc; end
      1: begin w[11:0] = cur_x_mag; w[15] = cur_x_neg; w[27:16] = cur_y_mag; w[31] = cur_y_neg; end
      2: w = cur_base;
      default: begin w[7:0] = cur_hgt; w[31] = cur_hgt_en; end
    endcase
    return w;
  endfunction

  task automatic chk(input logic ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: got %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic check_all(input string tag);
    for (int i = 0; i < 4; i++) begin
      rd_addr = 3'(i);
      #1;
      chk(rd_data == m_pend[i], tag, $sformatf("pending[%0d]", i), rd_data, m_pend[i]);
      chk(act_word(i) == m_act[i], tag, $sformatf("active[%0d]", i), act_word(i), m_act[i]);
    end
    rd_addr = 3'd4;
    #1;
    chk(rd_data == {31'b0, m_armed}, tag, "status", rd_data, {31'b0, m_armed});
  endtask

  // one cycle of stimulus; starts and ends just after a falling edge
  task automatic step(input logic w, input logic [2:0] a, input logic [31:0] d,
                      input logic vb, input string tag);
    logic [31:0] np [4];
    logic arm_now, cancel, armed_eff;
    np = m_pend;
    arm_now = w && (a == 3'd2 || (a == 3'd0 && d[1:0] != 2'b00 && m_act[0][1:0] == 2'b00));
    cancel  = w && !arm_now && (a <= 3'd3);
    if (w && a <= 3'd3) np[a[1:0]] = d & mask_of(int'(a[1:0]));
    armed_eff = arm_now || (m_armed && !cancel);
    if (vb && armed_eff) m_act = np;
    m_armed = vb ? 1'b0 : armed_eff;
    m_pend  = np;
    wr_en = w; wr_addr = a; wr_data = d; vblank = vb;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0; vblank = 1'b0;
    check_all(tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got %h expected %h", 32'd0, 32'd1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0; vblank = 1'b0; rd_addr = '0;
    for (int i = 0; i < 4; i++) begin m_pend[i] = '0; m_act[i] = '0; end
    m_armed = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check_all("R1 reset");

    // R2/R5: enabling control arms, position then height cancel; nothing moves
    step(1'b1, 3'd0, 32'h0000_0003, 1'b0, "R4 arm on enable");
    step(1'b1, 3'd1, 32'h8010_0020, 1'b0, "R5 pos cancels");
    step(1'b1, 3'd3, 32'h8000_0030, 1'b0, "R2 pending only");
    step(1'b0, 3'd0, 32'h0, 1'b1, "R6 vblank unarmed");
    // R3: ordered sequence then vblank
    step(1'b1, 3'd2, 32'hCAFE_0000, 1'b0, "R3 base arms");
    step(1'b0, 3'd0, 32'h0, 1'b0, "R2 waits for vblank");
    step(1'b0, 3'd0, 32'h0, 1'b1, "R3 transfer");
    // R8: move only
    step(1'b1, 3'd1, 32'h0055_8044, 1'b0, "R8 pos");
    step(1'b1, 3'd2, 32'hCAFE_0000, 1'b0, "R8 base");
    step(1'b0, 3'd0, 32'h0, 1'b1, "R8 moved");
    // R9: layout readback
    step(1'b1, 3'd0, 32'hFFFF_FFFF, 1'b0, "R9 ctrl mask");
    step(1'b1, 3'd3, 32'hFFFF_FFFF, 1'b0, "R9 hgt mask");
    // R7: arm with vblank in the same cycle
    step(1'b1, 3'd2, 32'h1234_5678, 1'b1, "R7 same cycle");
    // R11: cancel with vblank
    step(1'b1, 3'd2, 32'h0BAD_0000, 1'b0, "R11 arm");
    step(1'b1, 3'd1, 32'h0001_0001, 1'b1, "R11 cancel at vblank");
    // R10: undefined address keeps armed flag
    step(1'b1, 3'd2, 32'h0BAD_0000, 1'b0, "R10 arm");
    step(1'b1, 3'd5, 32'hFFFF_FFFF, 1'b0, "R10 ignored");
    step(1'b0, 3'd0, 32'h0, 1'b1, "R10 still armed");

    // near-exhaustive sweep
    for (int ae = 0; ae < 2; ae++) begin
      for (int pre = 0; pre < 2; pre++) begin
        for (int a = 0; a < 8; a++) begin
          for (int vb = 0; vb < 2; vb++) begin
            for (int dv = 0; dv < 3; dv++) begin
              logic [31:0] d;
              string tg;
              d = (dv == 0) ? 32'hA5C3_96E1 : (dv == 1) ? 32'h3B1D_7402 : 32'h0000_0310;
              tg = (a == 2) ? "R3" : (a == 0) ? "R4_R5" : (a >= 4) ? "R10" : "R5";
              tg = $sformatf("%s%s sweep a=%0d pre=%0d ae=%0d dv=%0d", tg,
                             (vb != 0) ? " R7_R11" : "", a, pre, ae, dv);
              step(1'b1, 3'd0, (ae != 0) ? 32'h2 : 32'h0, 1'b0, "setup");
              step(1'b1, 3'd2, 32'h0000_1000, 1'b1, "setup");
              if (pre != 0) step(1'b1, 3'd2, 32'h0000_2000, 1'b0, "setup");
              step(1'b1, 3'(a), d, 1'(vb), tg);
              step(1'b0, 3'd0, 32'h0, 1'b1, tg);
            end
          end
        end
      end
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule